// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and arbitrating between them with a per-address chooser. The first predictor correlates across branches. It indexes a table of 2-bit saturating counters with the shift register of recent outcomes XORed with PC bits. The second predictor is two-level and per-branch. A table indexed by PC bits holds each branch's own recent outcomes, and that history, XORed with PC bits, selects a 3-bit saturating counter.

The fetch side drives a PC on the lookup port. In the same cycle, combinationally, it receives the final direction, both component directions and which component was selected. When the branch resolves, the back end presents the PC, the real outcome and the two component directions it was given at lookup. On the next clock edge the block trains both component counters, adjusts the chooser and shifts the outcome into both histories. Histories are updated only at resolution. Table depths and history lengths are parameters.

Top module: `tourney_pred`

## Requirements
- R1: After reset every global counter is 1, every local counter is 3, every chooser counter is 1, and every history is zero. Each lookup then returns not taken for both components and for the final result, with the local component selected.
- R2: The global component reads its 2-bit counter at index (global history) XOR (PC bits starting at bit ALIGN, GHIST_W wide). It returns taken when the counter is 2 or more.
- R3: The local component reads a history at the PC bits starting at bit ALIGN, LHT_IDX_W wide. That history XOR the PC bits starting at ALIGN, LHIST_W wide, indexes a 3-bit counter. It returns taken when the counter is 4 or more.
- R4: The final prediction equals the global component when the chooser counter at PC bits [ALIGN +: CHOOSE_IDX_W] has its MSB set. Otherwise it equals the local component.
- R5: On each valid update, both the global counter and the local counter are trained toward the real outcome, whichever component was selected. Counters saturate at 0 and at their maximum (3 and 7).
- R6: On a valid update where only the global component was right, the chooser counter is incremented, saturating at 3. Where only the local component was right, it is decremented, saturating at 0.
- R7: When both components were right, or both were wrong, the chooser counter keeps its value.
- R8: On a valid update the global history and the local history entry of the updated branch each shift left and take the outcome into bit 0. Counter indices are formed from the histories as they stood before this shift.
- R9: While upd_valid is low, no table or history changes, whatever the other update inputs carry.
- R10: Lookups read the current state combinationally. An update takes effect from the clock edge that registers it, so a lookup in the same cycle sees the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC being looked up |
| pred_taken | output | 1 | Final predicted direction |
| pred_global | output | 1 | Global component direction |
| pred_local | output | 1 | Local component direction |
| pred_use_global | output | 1 | 1 when the chooser selects the global component |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_pred_global | input | 1 | Global direction given at lookup |
| upd_pred_local | input | 1 | Local direction given at lookup |

## Verification
The bench targets saturation at both ends of all three counter widths. A design that wrapped a counter instead of saturating would flip a strongly held direction after one extra outcome. It also drives updates where both components agree, right or wrong. A chooser that moved on those would switch components without cause. An alternating pattern on one branch exercises the local history. If indices were formed after the shift, or the new bit entered at the wrong end, the local component would not learn the pattern. Updates with valid low carry random data, and a design that ignored the valid would drift away from the reference model.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Chooser adjustment decided at update time
  typedef enum logic [1:0] {
    CH_HOLD      = 2'd0,
    CH_TO_GLOBAL = 2'd1,
    CH_TO_LOCAL  = 2'd2
  } ch_move_e;

endpackage

// File: rtl/tp_ctr_table.sv
// Table of saturating counters: one combinational read, one training write.
module tp_ctr_table #(
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] MAXV = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] INIT = MAXV >> 1;  // weakly not taken

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur;
  logic [CTR_W-1:0] nxt;

  assign rd_taken = mem[rd_idx][CTR_W-1];

  always_comb begin
    cur = mem[wr_idx];
    if (wr_up) begin
      nxt = (cur == MAXV) ? cur : cur + 1'b1;
    end else begin
      nxt = (cur == '0) ? cur : cur - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= INIT;
      end
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end

endmodule

// File: rtl/tp_hist_table.sv
// Per-branch history table: two read ports (lookup, update) and one shift write.
module tp_hist_table #(
  parameter int IDX_W  = 3,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [HIST_W-1:0] rd0_hist,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [HIST_W-1:0] rd1_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] nxt;

  assign rd0_hist = mem[rd0_idx];
  assign rd1_hist = mem[rd1_idx];

  always_comb begin
    nxt = {mem[wr_idx][HIST_W-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W         = 32,
  parameter int ALIGN        = 2,
  parameter int GHIST_W      = 12,
  parameter int LHT_IDX_W    = 10,
  parameter int LHIST_W      = 10,
  parameter int CHOOSE_IDX_W = 12,
  parameter int GCTR_W       = 2,
  parameter int LCTR_W       = 3,
  parameter int CCTR_W       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  output logic            pred_use_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_pred_global,
  input  logic            upd_pred_local
);
  import tp_pkg::*;

  // ---------------- global history register ----------------
  logic [GHIST_W-1:0] ghr_q;
  logic [GHIST_W-1:0] ghr_d;

  always_comb begin
    ghr_d = {ghr_q[GHIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr_q <= '0;
    end else if (upd_valid) begin
      ghr_q <= ghr_d;
    end
  end

  // ---------------- index formation ----------------
  logic [GHIST_W-1:0]      p_gidx, u_gidx;
  logic [LHT_IDX_W-1:0]    p_hidx, u_hidx;
  logic [LHIST_W-1:0]      p_lhist, u_lhist;
  logic [LHIST_W-1:0]      p_lidx, u_lidx;
  logic [CHOOSE_IDX_W-1:0] p_cidx, u_cidx;

  always_comb begin
    p_gidx = ghr_q ^ pred_pc[ALIGN +: GHIST_W];
    u_gidx = ghr_q ^ upd_pc[ALIGN +: GHIST_W];
    p_hidx = pred_pc[ALIGN +: LHT_IDX_W];
    u_hidx = upd_pc[ALIGN +: LHT_IDX_W];
    p_lidx = p_lhist ^ pred_pc[ALIGN +: LHIST_W];
    u_lidx = u_lhist ^ upd_pc[ALIGN +: LHIST_W];
    p_cidx = pred_pc[ALIGN +: CHOOSE_IDX_W];
    u_cidx = upd_pc[ALIGN +: CHOOSE_IDX_W];
  end

  logic pc_unused;
  assign pc_unused = ^{pred_pc, upd_pc};

  // ---------------- chooser training decision ----------------
  ch_move_e ch_move;
  logic     g_right, l_right;

  always_comb begin
    g_right = (upd_pred_global == upd_taken);
    l_right = (upd_pred_local == upd_taken);
    if (g_right && !l_right) begin
      ch_move = CH_TO_GLOBAL;
    end else if (l_right && !g_right) begin
      ch_move = CH_TO_LOCAL;
    end else begin
      ch_move = CH_HOLD;
    end
  end

  // ---------------- tables ----------------
  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) i_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (p_gidx),
    .rd_taken(pred_global),
    .wr_en   (upd_valid),
    .wr_idx  (u_gidx),
    .wr_up   (upd_taken)
  );

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) i_lhist (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd0_idx (p_hidx),
    .rd0_hist(p_lhist),
    .rd1_idx (u_hidx),
    .rd1_hist(u_lhist),
    .wr_en   (upd_valid),
    .wr_idx  (u_hidx),
    .wr_bit  (upd_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) i_lctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (p_lidx),
    .rd_taken(pred_local),
    .wr_en   (upd_valid),
    .wr_idx  (u_lidx),
    .wr_up   (upd_taken)
  );

  tp_ctr_table #(.IDX_W(CHOOSE_IDX_W), .CTR_W(CCTR_W)) i_choose (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (p_cidx),
    .rd_taken(pred_use_global),
    .wr_en   (upd_valid && (ch_move != CH_HOLD)),
    .wr_idx  (u_cidx),
    .wr_up   (ch_move == CH_TO_GLOBAL)
  );

  // ---------------- final selection ----------------
  always_comb begin
    pred_taken = pred_use_global ? pred_global : pred_local;
  end

endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pred_pc,
  input logic            pred_taken,
  input logic            pred_global,
  input logic            pred_local,
  input logic            pred_use_global,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic            upd_pred_global,
  input logic            upd_pred_local
);

  AST_NO_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!$stable(pred_pc) ||
                    $stable({pred_taken, pred_global, pred_local, pred_use_global}))); // R9

  AST_CHOOSER_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_pred_global == upd_pred_local) && (pred_pc == upd_pc))
      |=> (!$stable(pred_pc) || $stable(pred_use_global))); // R7

  AST_CHOOSER_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (pred_pc == upd_pc) && pred_use_global &&
     (upd_pred_global == upd_taken) && (upd_pred_local != upd_taken))
      |=> (!$stable(pred_pc) || pred_use_global)); // R6

  AST_CHOOSER_KEEP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (pred_pc == upd_pc) && !pred_use_global &&
     (upd_pred_local == upd_taken) && (upd_pred_global != upd_taken))
      |=> (!$stable(pred_pc) || !pred_use_global)); // R6

  AST_FINAL_FROM_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global == pred_local) |-> (pred_taken == pred_global)); // R4

endmodule

bind tourney_pred tourney_pred_chk #(.PC_W(PC_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pred_pc        (pred_pc),
  .pred_taken     (pred_taken),
  .pred_global    (pred_global),
  .pred_local     (pred_local),
  .pred_use_global(pred_use_global),
  .upd_valid      (upd_valid),
  .upd_pc         (upd_pc),
  .upd_taken      (upd_taken),
  .upd_pred_global(upd_pred_global),
  .upd_pred_local (upd_pred_local)
);

// File: tb/test_tourney_pred.sv
module test_tourney_pred;
  localparam int PW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rst_n;
  logic [PW-1:0] pred_pc, upd_pc;
  logic          pred_taken, pred_global, pred_local, pred_use_global;
  logic          upd_valid, upd_taken, upd_pred_global, upd_pred_local;

  tourney_pred #(
    .PC_W(PW), .ALIGN(2), .GHIST_W(4), .LHT_IDX_W(3),
    .LHIST_W(4), .CHOOSE_IDX_W(4)
  ) i_tourney_pred (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local),
    .pred_use_global(pred_use_global), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_pred_global(upd_pred_global),
    .upd_pred_local(upd_pred_local)
  );

  // ---------------- reference model ----------------
  logic [1:0] gm [16];
  logic [2:0] lm [16];
  logic [1:0] cm [16];
  logic [3:0] lht [8];
  logic [3:0] ghr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) begin
      gm[i] = 2'd1; lm[i] = 3'd3; cm[i] = 2'd1;
    end
    for (int i = 0; i < 8; i++) lht[i] = 4'd0;
    ghr = 4'd0;
  endfunction

  function automatic logic m_pg(input logic [PW-1:0] pc);
    return gm[ghr ^ pc[5:2]][1];
  endfunction

  function automatic logic m_pl(input logic [PW-1:0] pc);
    return lm[lht[pc[4:2]] ^ pc[5:2]][2];
  endfunction

  function automatic logic m_ug(input logic [PW-1:0] pc);
    return cm[pc[5:2]][1];
  endfunction

  function automatic void m_update(input logic [PW-1:0] pc, input logic t,
                                   input logic pg, input logic pl);
    logic [3:0] gi, li, ci;
    gi = ghr ^ pc[5:2];
    li = lht[pc[4:2]] ^ pc[5:2];
    ci = pc[5:2];
    if (t) begin
      if (gm[gi] != 2'd3) gm[gi] = gm[gi] + 2'd1;
      if (lm[li] != 3'd7) lm[li] = lm[li] + 3'd1;
    end else begin
      if (gm[gi] != 2'd0) gm[gi] = gm[gi] - 2'd1;
      if (lm[li] != 3'd0) lm[li] = lm[li] - 3'd1;
    end
    if ((pg == t) && (pl != t) && (cm[ci] != 2'd3)) cm[ci] = cm[ci] + 2'd1;
    if ((pl == t) && (pg != t) && (cm[ci] != 2'd0)) cm[ci] = cm[ci] - 2'd1;
    lht[pc[4:2]] = {lht[pc[4:2]][2:0], t};
    ghr = {ghr[2:0], t};
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Drive a lookup and (optionally) an update in the same cycle, check the
  // lookup before the edge (R10), then advance the model at the edge.
  task automatic step(input logic [PW-1:0] pc, input logic t, input logic v,
                      input logic pg, input logic pl, input string ph);
    logic eg, el, eu;
    @(negedge clk);
    pred_pc = pc; upd_pc = pc; upd_valid = v; upd_taken = t;
    upd_pred_global = pg; upd_pred_local = pl;
    #1;
    eg = m_pg(pc); el = m_pl(pc); eu = m_ug(pc);
    chk((ph == "") ? "R2" : ph, "pred_global", pred_global, eg);
    chk((ph == "") ? "R3" : ph, "pred_local", pred_local, el);
    chk((ph == "") ? "R6" : ph, "pred_use_global", pred_use_global, eu);
    chk((ph == "") ? "R4" : ph, "pred_taken", pred_taken, eu ? eg : el);
    @(posedge clk);
    if (v) m_update(pc, t, pg, pl);
  endtask

  task automatic auto_step(input logic [PW-1:0] pc, input logic t, input string ph);
    step(pc, t, 1'b1, m_pg(pc), m_pl(pc), ph);
  endtask

  initial begin
    logic [PW-1:0] pc;
    logic t;
    void'($urandom(32'd4242));
    m_reset();
    rst_n = 1'b0; pred_pc = '0; upd_pc = '0; upd_valid = 1'b0;
    upd_taken = 1'b0; upd_pred_global = 1'b0; upd_pred_local = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen on every chooser/global index
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pred_pc = PW'(i << 2); upd_valid = 1'b0;
      #1;
      chk("R1", "pred_global", pred_global, 1'b0);
      chk("R1", "pred_local", pred_local, 1'b0);
      chk("R1", "pred_use_global", pred_use_global, 1'b0);
      chk("R1", "pred_taken", pred_taken, 1'b0);
    end

    // R5: saturation of both component counters, then back down
    repeat (12) auto_step(16'h0010, 1'b1, "R5");
    repeat (14) auto_step(16'h0010, 1'b0, "R5");

    // R8: alternating outcome on one branch exercises local history shifting
    for (int i = 0; i < 40; i++) auto_step(16'h0024, i[0], "R8");

    // R6: chooser saturates toward global, then toward local
    repeat (5) step(16'h0018, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(16'h0018, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    repeat (5) step(16'h0018, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    step(16'h0018, 1'b0, 1'b0, 1'b0, 1'b0, "R6");

    // R7: both right / both wrong never move the chooser
    repeat (2) step(16'h001c, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    repeat (4) step(16'h001c, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    repeat (4) step(16'h001c, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
    step(16'h001c, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

    // R9: invalid updates with random payload change nothing
    for (int i = 0; i < 10; i++) begin
      pc = PW'($urandom_range(0, 63) << 2);
      step(pc, 1'($urandom), 1'b0, 1'($urandom), 1'($urandom), "R9");
    end
    for (int i = 0; i < 16; i++) step(PW'(i << 2), 1'b0, 1'b0, 1'b0, 1'b0, "R9");

    // R10: same-cycle lookup of the branch being updated sees the old state
    repeat (6) auto_step(16'h0030, 1'b1, "R10");

    // Random mix: per-output tags R2, R3, R4, R6
    for (int i = 0; i < 400; i++) begin
      pc = PW'($urandom_range(0, 63) << 2);
      t = ($urandom_range(0, 3) != 0) ^ pc[3];
      if ($urandom_range(0, 7) == 0) begin
        step(pc, t, 1'b1, 1'($urandom), 1'($urandom), "");
      end else begin
        auto_step(pc, t, "");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule